// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is an SMBus/I2C-style target. It lets a host reach a small bank of byte registers that set up a clock-distribution function. The block runs on a fast system clock and oversamples the bus clock and data lines. Each line passes through a synchroniser and a glitch filter. From the filtered lines the block finds start, repeated-start and stop conditions. It accepts one fixed write address and one fixed read address. To acknowledge a byte or send read data, it pulls the data line low through an open-drain enable.

Every transfer names a register index first. A write then sends a byte count and the data bytes. A read uses a repeated start to switch direction. The target answers with the stored count byte, then sends register contents from the chosen index upward until the host declines a byte.

The bank holds the following:
- A configuration byte. Its spread, spread-amount and PLL/fan-out fields start out under the control of strap pins sampled at reset. A control bit hands those fields to the host for good.
- Per-output enable bits and per-output stoppable bits.
- Two constant identification bytes.
- A writable byte that sets the count reported on reads.

Top module: `smb_idx_target`

## Requirements
- R1: The target acknowledges the address bytes 0xD8 (write) and 0xD9 (read). Any other address byte is not acknowledged. After a refused address, the target drives nothing until the next start condition.
- R2: A write transfer has the form 0xD8, index N, count X, then data. The target acknowledges every byte. The data bytes go to registers N, N+1, and so on, and the index advances by one after each stored byte.
- R3: Data bytes beyond the count X are acknowledged, but they change no register and do not advance the index.
- R4: A read transfer has the form 0xD8, index N, repeated start, 0xD9. The target first sends the count byte (register 6). It then sends registers N, N+1, and so on, and it stops driving after the host's not-acknowledge.
- R5: Register 6 resets to 0x07. It is writable, and its value is the first byte of every read.
- R6: Register 4 reads 0x01 and register 5 reads 0x40. Writes to either are acknowledged and have no effect. Indexes 7 and above read 0x00 and ignore writes.
- R7: After reset, register 0 holds the strap pins (spread amount[1:0], spread on, PLL mode) in bits [4:1], 1 in bit 0, and 0 in bits [7:5]. While bit 0 is 1, the function outputs follow the live strap pins, and writes to bits [4:1] are ignored.
- R8: Writing 0 to register 0 bit 0 hands the functions to register bits [4:1] permanently. Bit 0 cannot return to 1, and strap changes no longer affect the outputs.
- R9: The register 0 fields are: bits [4:3] spread amount (00 = 0.125%, 01 = 0.25%, 10 = 0.375%, 11 = 0.5% down), bit 2 spread on, bit 1 PLL mode (1) or fan-out (0). Bit 7 selects float in power-down and bit 6 selects float in stop (0 = driven, 1 = Hi-Z).
- R10: Register 1 resets to 0xFF and register 2 to 0x00. Output enables and stoppable flags come from bits {6,5,2,1} of each register, MSB first. Reserved bits, and register 3, read back as written.
- R11: The data-line drive changes only while the filtered clock is low. A stop releases the data line and returns the target to idle. Pulses on either line shorter than FILT_LEN system clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 4 | Strap pins {spread amount[1:0], spread on, PLL mode} |
| spread_sel_o | output | 2 | Spread amount in use |
| spread_on_o | output | 1 | Spread enable in use |
| pll_mode_o | output | 1 | 1 = PLL path, 0 = fan-out |
| pd_float_o | output | 1 | Power-down park mode, 1 = Hi-Z |
| stop_float_o | output | 1 | Stop park mode, 1 = Hi-Z |
| out_en_o | output | 4 | Per-output enables |
| out_stoppable_o | output | 4 | Per-output stoppable flags |

## Verification
A wrong byte role or a wrong bit count appears at the ports within one byte time. Either the acknowledge slot on the data line is missing or extra, or the byte that comes back shifts by one position. A corrupted index shows up only on the next read, as data from the neighbouring register. A corrupted ownership bit shows up at once on the function outputs when the straps are moved. Reads of the constant registers and reads past the end of the bank catch a bank that decodes too few or too many indexes.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  ADDR_WR   = 8'hD8;
  localparam logic [7:0]  ADDR_RD   = 8'hD9;
  localparam int unsigned NUM_REGS  = 7;
  localparam int unsigned IDX_CFG   = 0;
  localparam int unsigned IDX_OEN   = 1;
  localparam int unsigned IDX_VREV  = 4;
  localparam int unsigned IDX_DEVID = 5;
  localparam int unsigned IDX_CNT   = 6;
  localparam logic [7:0]  VREV_VAL  = 8'h01;
  localparam logic [7:0]  DEVID_VAL = 8'h40;
  localparam logic [7:0]  CNT_RST   = 8'h07;
  localparam logic [7:0]  OEN_RST   = 8'hFF;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} bus_state_e;
  typedef enum logic [1:0] {ROLE_ADDR, ROLE_INDEX, ROLE_COUNT, ROLE_DATA} byte_role_e;

  // host-owned once bit 0 is cleared; fields [4:1] open only when owned
  function automatic logic [7:0] cfg_merge(input logic [7:0] old_v, input logic [7:0] wr_v);
    logic own_n;
    own_n = old_v[0] & wr_v[0];
    return {wr_v[7:5], own_n ? old_v[4:1] : wr_v[4:1], own_n};
  endfunction

  function automatic logic [3:0] per_output(input logic [7:0] r);
    return {r[6], r[5], r[2], r[1]};
  endfunction

  function automatic logic idx_writable(input logic [7:0] idx);
    return (idx < 8'(NUM_REGS)) && (idx != 8'(IDX_VREV)) && (idx != 8'(IDX_DEVID));
  endfunction

  function automatic logic addr_hit(input logic [7:0] b);
    return (b == ADDR_WR) || (b == ADDR_RD);
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       run_q;
  logic                level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      run_q   <= '0;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      if (sync_q[SYNC_LEN-1] == level_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        level_q <= ~level_q;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign line_o = level_q;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strap_i,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] cnt_o,
  output logic       cfg_own_o,
  output logic [1:0] spread_sel_o,
  output logic       spread_on_o,
  output logic       pll_mode_o,
  output logic       pd_float_o,
  output logic       stop_float_o,
  output logic [3:0] out_en_o,
  output logic [3:0] out_stoppable_o
);
  localparam int unsigned IW = $clog2(NUM_REGS);

  logic [7:0] regs_q [NUM_REGS];
  logic       seeded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      regs_q[IDX_CFG] <= 8'h01;
      regs_q[IDX_OEN] <= OEN_RST;
      regs_q[IDX_CNT] <= CNT_RST;
      seeded_q        <= 1'b0;
    end else begin
      if (!seeded_q) begin
        seeded_q           <= 1'b1;
        regs_q[IDX_CFG][4:1] <= strap_i;
      end
      if (wr_en && idx_writable(wr_idx)) begin
        if (wr_idx == 8'(IDX_CFG)) regs_q[IDX_CFG] <= cfg_merge(regs_q[IDX_CFG], wr_data);
        else                       regs_q[wr_idx[IW-1:0]] <= wr_data;
      end
    end
  end

  always_comb begin
    if (rd_idx >= 8'(NUM_REGS))        rd_data = 8'h00;
    else if (rd_idx == 8'(IDX_VREV))   rd_data = VREV_VAL;
    else if (rd_idx == 8'(IDX_DEVID))  rd_data = DEVID_VAL;
    else                               rd_data = regs_q[rd_idx[IW-1:0]];
  end

  assign cnt_o           = regs_q[IDX_CNT];
  assign cfg_own_o       = ~regs_q[IDX_CFG][0];
  assign spread_sel_o    = cfg_own_o ? regs_q[IDX_CFG][4:3] : strap_i[3:2];
  assign spread_on_o     = cfg_own_o ? regs_q[IDX_CFG][2]   : strap_i[1];
  assign pll_mode_o      = cfg_own_o ? regs_q[IDX_CFG][1]   : strap_i[0];
  assign pd_float_o      = regs_q[IDX_CFG][7];
  assign stop_float_o    = regs_q[IDX_CFG][6];
  assign out_en_o        = per_output(regs_q[IDX_OEN]);
  assign out_stoppable_o = per_output(regs_q[2]);
endmodule

// File: rtl/smb_idx_target.sv
module smb_idx_target
  import smb_regs_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [3:0] strap_i,
  output logic [1:0] spread_sel_o,
  output logic       spread_on_o,
  output logic       pll_mode_o,
  output logic       pd_float_o,
  output logic       stop_float_o,
  output logic [3:0] out_en_o,
  output logic [3:0] out_stoppable_o
);
  logic scl_f, sda_f, scl_q, sda_q;
  logic scl_rise, scl_fall, ev_start, ev_stop;
  bus_state_e state_q;
  byte_role_e role_q;
  logic [7:0] shreg_q, tx_sh_q, cur_idx, wr_left_q, rd_data, cnt_val;
  logic [3:0] bcnt_q;
  logic       tx_mode_q, sda_oe_q, rx_done, ack_byte, wr_fire, cfg_own;

  smb_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
  smb_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign rx_done  = (state_q == ST_RX) && scl_fall && (bcnt_q == 4'd8);
  assign ack_byte = (role_q == ROLE_ADDR) ? addr_hit(shreg_q) : 1'b1;
  assign wr_fire  = rx_done && (role_q == ROLE_DATA) && (wr_left_q != 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      role_q    <= ROLE_ADDR;
      shreg_q   <= '0;
      tx_sh_q   <= '0;
      bcnt_q    <= '0;
      cur_idx   <= '0;
      wr_left_q <= '0;
      tx_mode_q <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (ev_start) begin
      state_q   <= ST_RX;
      role_q    <= ROLE_ADDR;
      bcnt_q    <= '0;
      tx_mode_q <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (ev_stop) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && bcnt_q != 4'd8) begin
            shreg_q <= {shreg_q[6:0], sda_f};
            bcnt_q  <= bcnt_q + 4'd1;
          end else if (rx_done) begin
            bcnt_q <= '0;
            if (!ack_byte) begin
              state_q <= ST_IDLE;
            end else begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_RX_ACK;
              case (role_q)
                ROLE_ADDR:  if (shreg_q == ADDR_RD) tx_mode_q <= 1'b1;
                            else role_q <= ROLE_INDEX;
                ROLE_INDEX: begin cur_idx <= shreg_q; role_q <= ROLE_COUNT; end
                ROLE_COUNT: begin wr_left_q <= shreg_q; role_q <= ROLE_DATA; end
                default:    if (wr_fire) begin
                              cur_idx   <= cur_idx + 8'd1;
                              wr_left_q <= wr_left_q - 8'd1;
                            end
              endcase
            end
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          if (tx_mode_q) begin
            tx_sh_q  <= cnt_val;
            sda_oe_q <= ~cnt_val[7];
            state_q  <= ST_TX;
          end else begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bcnt_q == 4'd7) begin
            sda_oe_q <= 1'b0;
            bcnt_q   <= '0;
            state_q  <= ST_TX_ACK;
          end else begin
            tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
            sda_oe_q <= ~tx_sh_q[6];
            bcnt_q   <= bcnt_q + 4'd1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_f) begin
            state_q <= ST_IDLE;
          end else if (scl_fall) begin
            tx_sh_q  <= rd_data;
            sda_oe_q <= ~rd_data[7];
            cur_idx  <= cur_idx + 8'd1;
            state_q  <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  smb_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .wr_en(wr_fire), .wr_idx(cur_idx), .wr_data(shreg_q),
    .rd_idx(cur_idx), .rd_data(rd_data), .cnt_o(cnt_val),
    .cfg_own_o(cfg_own),
    .spread_sel_o(spread_sel_o), .spread_on_o(spread_on_o), .pll_mode_o(pll_mode_o),
    .pd_float_o(pd_float_o), .stop_float_o(stop_float_o),
    .out_en_o(out_en_o), .out_stoppable_o(out_stoppable_o));
endmodule

// File: rtl/smb_idx_target_chk.sv
module smb_idx_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe_o,
  input logic       scl_f,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       wr_fire,
  input logic [7:0] cur_idx,
  input logic       cfg_own,
  input logic [1:0] spread_sel_o,
  input logic       spread_on_o,
  input logic       pll_mode_o
);
  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_f); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe_o); // R11
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe_o); // R1
  AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (cur_idx == $past(cur_idx) + 8'd1)); // R2
  AST_OWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_own |=> cfg_own); // R8
  AST_STRAPS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_own && !wr_fire) |=> $stable({spread_sel_o, spread_on_o, pll_mode_o})); // R8
endmodule

bind smb_idx_target smb_idx_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .scl_f(scl_f),
  .ev_start(ev_start), .ev_stop(ev_stop), .wr_fire(wr_fire), .cur_idx(cur_idx),
  .cfg_own(cfg_own), .spread_sel_o(spread_sel_o), .spread_on_o(spread_on_o),
  .pll_mode_o(pll_mode_o));

// File: tb/smb_idx_target_tb_top.sv
module smb_idx_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_h = 1'b1, sda_h = 1'b1, glitch_en = 1'b0;
  logic [3:0] strap = 4'b1010;
  logic sda_oe;
  logic [1:0] spread_sel;
  logic spread_on, pll_mode, pd_float, stop_float;
  logic [3:0] out_en, out_stp;
  wire  sda_bus = sda_h & ~sda_oe;

  smb_idx_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .spread_sel_o(spread_sel), .spread_on_o(spread_on),
    .pll_mode_o(pll_mode), .pd_float_o(pd_float), .stop_float_o(stop_float),
    .out_en_o(out_en), .out_stoppable_o(out_stp));

  localparam int QT = 10;
  // {index, written byte, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    24'h01_9B_9B, 24'h02_42_42, 24'h03_A5_A5, 24'h04_FF_01,
    24'h05_00_40, 24'h07_55_00, 24'h06_07_07, 24'hC8_11_00};

  int checks = 0, errors = 0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [8];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(QT); scl_h = 1'b1; tick(QT);
    sda_h = 1'b0; tick(QT); scl_h = 1'b0; tick(QT);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(QT); scl_h = 1'b1; tick(QT);
    sda_h = 1'b1; tick(2*QT);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; tick(QT); scl_h = 1'b1;
    if (glitch_en) begin
      tick(4); scl_h = 1'b0; tick(2); scl_h = 1'b1; tick(4);
      if (b) begin sda_h = 1'b0; tick(2); sda_h = 1'b1; end
      else tick(2);
      tick(8);
    end else tick(2*QT);
    scl_h = 1'b0; tick(QT);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; tick(QT); scl_h = 1'b1; tick(QT);
    ack = !sda_bus; tick(QT); scl_h = 1'b0; tick(QT);
  endtask

  task automatic read_byte(input logic last, output logic [7:0] d);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(QT); scl_h = 1'b1; tick(QT); d[i] = sda_bus; tick(QT); scl_h = 1'b0; tick(QT);
    end
    send_bit(last);
  endtask

  task automatic wr_seq(input logic [7:0] idx, input logic [7:0] cnt, input int nb);
    logic a, all_ack;
    bus_start();
    write_byte(8'hD8, a); all_ack = a;
    write_byte(idx, a);   all_ack &= a;
    write_byte(cnt, a);   all_ack &= a;
    for (int i = 0; i < nb; i++) begin write_byte(wbuf[i], a); all_ack &= a; end
    bus_stop();
    chk("R1 R2 write acks", {7'd0, all_ack}, 8'd1);
  endtask

  task automatic rd_block(input logic [7:0] idx, input int n);
    logic a, all_ack;
    bus_start();
    write_byte(8'hD8, a); all_ack = a;
    write_byte(idx, a);   all_ack &= a;
    bus_start();
    write_byte(8'hD9, a); all_ack &= a;
    for (int i = 0; i <= n; i++) read_byte(i == n, rbuf[i]);
    bus_stop();
    chk("R1 R4 read acks", {7'd0, all_ack}, 8'd1);
    checks++;
    if (sda_oe !== 1'b0) begin errors++; $display("FAIL R4: sda drive %0b after nack expected 0", sda_oe); end
  endtask

  function automatic string tag_for(input logic [7:0] idx);
    if (idx == 8'd4 || idx == 8'd5 || idx >= 8'd7) return "R6";
    if (idx == 8'd6) return "R5";
    return "R10";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    tick(10); rst_n = 1'b1; tick(10);
    // reset state
    chk("R10 enable reset", {4'd0, out_en}, 8'h0F);
    chk("R10 stoppable reset", {4'd0, out_stp}, 8'h00);
    chk("R7 straps drive", {4'd0, spread_sel, spread_on, pll_mode}, 8'h0A);
    chk("R9 park reset", {6'd0, pd_float, stop_float}, 8'h00);
    chk("R11 idle release", {7'd0, sda_oe}, 8'h00);
    rd_block(8'd0, 1);
    chk("R5 count reset", rbuf[0], 8'h07);
    chk("R7 cfg seeded", rbuf[1], 8'h15);

    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][15:8];
      wr_seq(VEC[v][23:16], 8'd1, 1);
      rd_block(VEC[v][23:16], 1);
      chk(tag_for(VEC[v][23:16]), rbuf[1], VEC[v][7:0]);
    end
    chk("R10 enables", {4'd0, out_en}, 8'h01);
    chk("R10 stoppable", {4'd0, out_stp}, 8'h09);

    // block write with a byte past the count
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00; wbuf[2] = 8'h77;
    wr_seq(8'd1, 8'd2, 3);
    rd_block(8'd1, 3);
    chk("R4 count first", rbuf[0], 8'h07);
    chk("R2 first data", rbuf[1], 8'hFF);
    chk("R2 second data", rbuf[2], 8'h00);
    chk("R3 extra dropped", rbuf[3], 8'hA5);
    rd_block(8'd3, 3);
    chk("R6 revision", rbuf[2], 8'h01);
    chk("R6 device id", rbuf[3], 8'h40);

    wbuf[0] = 8'h03; wr_seq(8'd6, 8'd1, 1);
    rd_block(8'd5, 2);
    chk("R5 new count", rbuf[0], 8'h03);
    chk("R5 count reg", rbuf[2], 8'h03);

    // foreign address
    bus_start();
    write_byte(8'hA0, a); chk("R1 foreign nack", {7'd0, a}, 8'd0);
    write_byte(8'hD8, a); chk("R1 silent after nack", {7'd0, a}, 8'd0);
    bus_stop();

    // straps own the functions
    strap = 4'b0111; tick(2);
    chk("R7 live straps", {4'd0, spread_sel, spread_on, pll_mode}, 8'h07);
    wbuf[0] = 8'hDF; wr_seq(8'd0, 8'd1, 1);
    rd_block(8'd0, 1);
    chk("R7 fields locked", rbuf[1], 8'hD5);
    chk("R9 park float", {6'd0, pd_float, stop_float}, 8'h03);

    // hand over to the host
    wbuf[0] = 8'h18; wr_seq(8'd0, 8'd1, 1);
    chk("R9 host fields", {4'd0, spread_sel, spread_on, pll_mode}, 8'h0C);
    strap = 4'b0101; tick(4);
    chk("R8 straps ignored", {4'd0, spread_sel, spread_on, pll_mode}, 8'h0C);
    wbuf[0] = 8'h05; wr_seq(8'd0, 8'd1, 1);
    rd_block(8'd0, 1);
    chk("R8 bit0 sticky", rbuf[1], 8'h04);
    chk("R9 new fields", {4'd0, spread_sel, spread_on, pll_mode}, 8'h02);

    // glitches on both lines
    glitch_en = 1'b1;
    wbuf[0] = 8'h3C; wr_seq(8'd3, 8'd1, 1);
    glitch_en = 1'b0;
    rd_block(8'd3, 1);
    chk("R11 glitch filtered", rbuf[1], 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule